// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer Channel Pair

This block holds two identical up-counting timer channels, X and Y, behind one byte-wide register bus. Each channel counts on one of three prescaled clock enables and holds two compare values, A and B. It records three events in a status register: a match on compare A, a match on compare B, and a counter wrap from all ones to zero. A control register per channel picks the count source and which compare match (if any) restarts the counter. It also says which of the three events may raise that channel's interrupt line.

A single bank-select bit in a shared register steers every per-channel register access to either X or Y. Software arms a status flag by reading it as 1 and then clears it by writing 0. The interrupt lines are registered: each one follows its flag ANDed with its enable.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, both channels read control 0x00, status 0x00, compare A 0xFF, compare B 0xFF and counter 0x00. The bank bit is 0 and all interrupt lines are low.
- R2: Control bits 2:0 pick the count source. Value k in 1..3 makes the counter advance in each cycle where `tick_en[k-1]` is high. Values 0 and 4..7 hold the counter still.
- R3: At a count event where the counter equals compare A, status bit 1 sets. At a count event where it equals compare B, status bit 2 sets.
- R4: Status bit 0 sets when a count event increments the counter from 0xFF to 0x00. A restart caused by a compare match does not set it.
- R5: With control bits 4:3 = 01, a count event that meets a compare-A match loads 0x00 instead of incrementing. With 10, the same applies to compare B.
- R6: With control bits 4:3 = 00 or 11, the counter is never restarted by a match and runs on past both compare values.
- R7: The interrupt lines are registered, one cycle behind the flags. `irq_mb` is status bit 2 gated by control bit 7. `irq_ma` is status bit 1 gated by control bit 6. `irq_ov` is status bit 0 gated by control bit 5.
- R8: Writing 0 to a status bit clears it only if a status read has returned that bit as 1 since it last cleared. Writing 1 has no effect. A new event in the same cycle as a clear wins, and the flag stays set.
- R9: Address 7, bit 0, is the bank bit. When it is 0, addresses 0..4 reach channel X (line index 0). When it is 1, they reach channel Y (index 1). The other channel is left untouched.
- R10: The register map is: 0 control, 1 status, 2 compare A, 3 compare B, 4 counter, 7 bank. Read data appears one cycle after `bus_rd` and holds when no read is made. A counter write loads the value and overrides that cycle's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | NTICK | Prescaled count enables |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| irq_mb | output | 2 | Compare-B interrupt, one per channel |
| irq_ma | output | 2 | Compare-A interrupt, one per channel |
| irq_ov | output | 2 | Overflow interrupt, one per channel |

## Verification
The bench builds the block with W = 8 and NTICK = 3. This makes the 0xFF-to-0x00 wrap reachable in a few hundred cycles, and lets every count-source code, both in-range and out-of-range, be driven. Directed sequences cover each clear mode (including the prohibited one), bank steering, the read-then-write flag protocol and stopped sources. A fixed-seed random phase then mixes enables with register traffic on both banks. All results are compared against a cycle model kept in the bench.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int AW    = 3;
  localparam int SRC_W = 3;
  localparam int NFLG  = 3;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_STAT = 3'd1;
  localparam logic [AW-1:0] A_CMPA = 3'd2;
  localparam logic [AW-1:0] A_CMPB = 3'd3;
  localparam logic [AW-1:0] A_CNT  = 3'd4;
  localparam logic [AW-1:0] A_BANK = 3'd7;

  localparam logic [1:0] CLR_NONE = 2'b00;
  localparam logic [1:0] CLR_A    = 2'b01;
  localparam logic [1:0] CLR_B    = 2'b10;

  // status / flag bit order: 0 overflow, 1 match A, 2 match B
  typedef struct packed {
    logic             ie_b;
    logic             ie_a;
    logic             ie_ov;
    logic [1:0]       clr;
    logic [SRC_W-1:0] src;
  } ctrl_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import cmt_pkg::*;
#(
  parameter int W     = 8,
  parameter int NTICK = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTICK-1:0] ticks,
  input  logic [SRC_W-1:0] src,
  input  logic [1:0]       clr,
  input  logic [W-1:0]     cmp_a,
  input  logic [W-1:0]     cmp_b,
  input  logic             ld_en,
  input  logic [W-1:0]     ld_val,
  output logic [W-1:0]     cnt,
  output logic [NFLG-1:0]  ev
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic tick, hit_a, hit_b, restart, wrap;

  always_comb begin
    tick = 1'b0;
    for (int k = 0; k < NTICK; k++)
      if (src == SRC_W'(k + 1)) tick = ticks[k];
  end

  assign hit_a   = tick && (cnt == cmp_a);
  assign hit_b   = tick && (cnt == cmp_b);
  assign restart = (clr == CLR_A && hit_a) || (clr == CLR_B && hit_b);
  assign wrap    = tick && !restart && (cnt == ALL1);
  assign ev      = {hit_b, hit_a, wrap};

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (ld_en) cnt <= ld_val;
    else if (tick)  cnt <= restart ? '0 : cnt + W'(1);
  end

  // R5
  clr_a_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && clr == CLR_A && cnt == cmp_a && !ld_en) |=> (cnt == '0));
  // R4
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ev[0] && !ld_en) |=> (cnt == '0));
  // R2
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    ((src == '0 || src > SRC_W'(NTICK)) && !ld_en) |=> $stable(cnt));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
  import cmt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NFLG-1:0] set,
  input  logic            rd_stat,
  input  logic            wr_stat,
  input  logic [NFLG-1:0] wdata,
  input  logic [NFLG-1:0] ie,
  output logic [NFLG-1:0] flag,
  output logic [NFLG-1:0] irq
);
  logic [NFLG-1:0] armed, clr_ok;

  assign clr_ok = {NFLG{wr_stat}} & ~wdata & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= '0;
      armed <= '0;
      irq   <= '0;
    end else begin
      irq <= flag & ie;
      for (int i = 0; i < NFLG; i++) begin
        if (set[i])         flag[i] <= 1'b1;
        else if (clr_ok[i]) flag[i] <= 1'b0;
        if (clr_ok[i])                 armed[i] <= 1'b0;
        else if (rd_stat && flag[i])   armed[i] <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NFLG; i++) begin : g_chk
    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> $past(flag[i] && ie[i]));
    // R8
    hold_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_stat && flag[i] && !armed[i]) |=> flag[i]);
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import cmt_pkg::*;
#(
  parameter int W     = 8,
  parameter int NTICK = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTICK-1:0] ticks,
  input  logic             sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [NFLG-1:0]  irq
);
  ctrl_t           ctrl;
  logic [W-1:0]    cmp_a, cmp_b, cnt;
  logic [NFLG-1:0] ev, flag;
  logic            wr_sel, ld_en, wr_stat, rd_stat;

  assign wr_sel  = sel && wr;
  assign ld_en   = wr_sel && addr == A_CNT;
  assign wr_stat = wr_sel && addr == A_STAT;
  assign rd_stat = sel && rd && addr == A_STAT;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      cmp_a <= '1;
      cmp_b <= '1;
    end else if (wr_sel) begin
      if (addr == A_CTRL) ctrl  <= ctrl_t'(wdata[7:0]);
      if (addr == A_CMPA) cmp_a <= wdata;
      if (addr == A_CMPB) cmp_b <= wdata;
    end
  end

  tmr_counter #(.W(W), .NTICK(NTICK)) u_cnt (
    .clk, .rst, .ticks,
    .src(ctrl.src), .clr(ctrl.clr),
    .cmp_a, .cmp_b,
    .ld_en, .ld_val(wdata),
    .cnt, .ev
  );

  tmr_flags u_flg (
    .clk, .rst,
    .set(ev), .rd_stat, .wr_stat,
    .wdata(wdata[NFLG-1:0]),
    .ie({ctrl.ie_b, ctrl.ie_a, ctrl.ie_ov}),
    .flag, .irq
  );

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) rdata = W'(ctrl);
    if (addr == A_STAT) rdata = W'(flag);
    if (addr == A_CMPA) rdata = cmp_a;
    if (addr == A_CMPB) rdata = cmp_b;
    if (addr == A_CNT)  rdata = cnt;
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import cmt_pkg::*;
#(
  parameter int W     = 8,
  parameter int NTICK = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTICK-1:0] tick_en,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  output logic [1:0]       irq_mb,
  output logic [1:0]       irq_ma,
  output logic [1:0]       irq_ov
);
  localparam int NCH = 2;

  logic         bank;
  logic [W-1:0] ch_rd [NCH];

  always_ff @(posedge clk) begin
    if (rst) bank <= 1'b0;
    else if (bus_wr && bus_addr == A_BANK) bank <= bus_wdata[0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic CH = 1'(c);
    logic [NFLG-1:0] irq_c;
    tmr_chan #(.W(W), .NTICK(NTICK)) u_ch (
      .clk, .rst, .ticks(tick_en),
      .sel(bank == CH), .wr(bus_wr), .rd(bus_rd),
      .addr(bus_addr), .wdata(bus_wdata),
      .rdata(ch_rd[c]), .irq(irq_c)
    );
    assign irq_ov[c] = irq_c[0];
    assign irq_ma[c] = irq_c[1];
    assign irq_mb[c] = irq_c[2];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= (bus_addr == A_BANK) ? W'(bank) : ch_rd[bank];
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R1
  irq_idle_chk: assert property (@(posedge clk)
    rst |=> (irq_mb == '0 && irq_ma == '0 && irq_ov == '0));
endmodule

// File: tb/sim_dual_cmp_timer.sv
module sim_dual_cmp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NTICK = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [NTICK-1:0] tick_en = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [1:0] irq_mb, irq_ma, irq_ov;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_cmp_timer #(.W(W), .NTICK(NTICK)) u0 (.*);

  // ---- reference model, updated on each rising edge
  logic [7:0] m_ctrl[2], m_ca[2], m_cb[2], m_cnt[2], m_rd;
  logic [2:0] m_flg[2], m_arm[2], m_irq[2];
  logic       m_bank;

  function automatic logic [7:0] ch_val(int c, logic [2:0] a);
    case (a)
      3'd0: return m_ctrl[c];
      3'd1: return {5'b0, m_flg[c]};
      3'd2: return m_ca[c];
      3'd3: return m_cb[c];
      3'd4: return m_cnt[c];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_ctrl[c] = 0; m_ca[c] = 8'hFF; m_cb[c] = 8'hFF; m_cnt[c] = 0;
        m_flg[c] = 0; m_arm[c] = 0; m_irq[c] = 0;
      end
      m_bank = 0; m_rd = 0;
    end else begin
      if (bus_rd) m_rd = (bus_addr == 3'd7) ? {7'b0, m_bank} : ch_val(int'(m_bank), bus_addr);
      for (int c = 0; c < 2; c++) begin
        logic [2:0] src, set, clrok, nf, na;
        logic [1:0] md;
        logic tk, ha, hb, rs, ov, sel;
        src = m_ctrl[c][2:0]; md = m_ctrl[c][4:3];
        tk = (src >= 1 && src <= 3) ? tick_en[src-1] : 1'b0;
        ha = tk && m_cnt[c] == m_ca[c];
        hb = tk && m_cnt[c] == m_cb[c];
        rs = (md == 2'b01 && ha) || (md == 2'b10 && hb);
        ov = tk && !rs && m_cnt[c] == 8'hFF;
        sel = (int'(m_bank) == c);
        m_irq[c] = m_flg[c] & {m_ctrl[c][7], m_ctrl[c][6], m_ctrl[c][5]};
        set = {hb, ha, ov};
        clrok = (sel && bus_wr && bus_addr == 3'd1) ? (~bus_wdata[2:0] & m_arm[c]) : 3'b0;
        for (int i = 0; i < 3; i++) begin
          nf[i] = set[i] ? 1'b1 : (clrok[i] ? 1'b0 : m_flg[c][i]);
          na[i] = clrok[i] ? 1'b0 :
                  ((sel && bus_rd && bus_addr == 3'd1 && m_flg[c][i]) ? 1'b1 : m_arm[c][i]);
        end
        m_flg[c] = nf; m_arm[c] = na;
        if (sel && bus_wr && bus_addr == 3'd4) m_cnt[c] = bus_wdata;
        else if (tk) m_cnt[c] = rs ? 8'h00 : m_cnt[c] + 8'd1;
        if (sel && bus_wr && bus_addr == 3'd0) m_ctrl[c] = bus_wdata;
        if (sel && bus_wr && bus_addr == 3'd2) m_ca[c] = bus_wdata;
        if (sel && bus_wr && bus_addr == 3'd3) m_cb[c] = bus_wdata;
      end
      if (bus_wr && bus_addr == 3'd7) m_bank = bus_wdata[0];
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R7: interrupt lines against the model on every falling edge
  always @(negedge clk) begin
    if (!rst && !done)
      for (int c = 0; c < 2; c++)
        chk("R7 irq lines", {5'b0, irq_mb[c], irq_ma[c], irq_ov[c]}, {5'b0, m_irq[c]});
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, string tag, output logic [7:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    v = bus_rdata;
    chk(tag, v, m_rd);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    logic pend;
    logic [2:0] a;
    void'($urandom(32'd20240611));
    idle(3); rst = 0;

    // R1 reset values in both banks
    for (int b = 0; b < 2; b++) begin
      wr(3'd7, 8'(b));
      rd(3'd0, "R1 ctrl", v); chk("R1 ctrl const", v, 8'h00);
      rd(3'd1, "R1 stat", v); chk("R1 stat const", v, 8'h00);
      rd(3'd2, "R1 cmpa", v); chk("R1 cmpa const", v, 8'hFF);
      rd(3'd3, "R1 cmpb", v); chk("R1 cmpb const", v, 8'hFF);
      rd(3'd4, "R1 cnt",  v); chk("R1 cnt const",  v, 8'h00);
    end

    // R9 bank steering
    wr(3'd7, 8'h00); wr(3'd2, 8'h10);
    wr(3'd7, 8'h01); rd(3'd2, "R9 Y untouched", v); chk("R9 Y cmpa const", v, 8'hFF);
    wr(3'd2, 8'h20); rd(3'd7, "R9 bank read", v); chk("R9 bank const", v, 8'h01);
    wr(3'd7, 8'h00); rd(3'd2, "R9 X kept", v); chk("R9 X cmpa const", v, 8'h10);

    // R5 clear on A, R3 flag A
    wr(3'd2, 8'h03); wr(3'd4, 8'h00); tick_en = 3'b001;
    wr(3'd0, 8'h49);
    for (int i = 0; i < 6; i++) rd(3'd4, "R5 clear on A cnt", v);
    rd(3'd1, "R3 stat A", v); chk("R3 flag A const", v & 8'h02, 8'h02);

    // R5 clear on B
    wr(3'd3, 8'h04); wr(3'd0, 8'h91);
    for (int i = 0; i < 6; i++) begin
      rd(3'd4, "R5 clear on B cnt", v);
      chk("R5 cnt bound", 8'(v > 8'h04), 8'h00);
    end
    rd(3'd1, "R3 stat B", v);

    // R6 prohibited clear mode runs past compare
    wr(3'd0, 8'h19); wr(3'd4, 8'h00); idle(8);
    rd(3'd4, "R6 mode 11 cnt", v); chk("R6 ran past", 8'(v > 8'h04), 8'h01);
    wr(3'd0, 8'h01); wr(3'd4, 8'h00); idle(8);
    rd(3'd4, "R6 mode 00 cnt", v);

    // R2 other enable bit, then stopped sources
    tick_en = 3'b100; wr(3'd0, 8'h03); idle(5); rd(3'd4, "R2 src3 cnt", v);
    tick_en = 3'b111;
    for (int s = 4; s < 8; s++) begin
      wr(3'd0, 8'(s)); rd(3'd4, "R2 stop a", v); idle(4); rd(3'd4, "R2 stop b", v2);
      chk("R2 stopped", v2, v);
    end

    // R4 overflow with interrupt, R8 flag protocol
    wr(3'd3, 8'h00); wr(3'd4, 8'hF0); tick_en = 3'b010; wr(3'd0, 8'h22);
    idle(30);
    wr(3'd0, 8'h20);
    rd(3'd4, "R4 cnt after wrap", v);
    wr(3'd1, 8'h00); // not armed: no effect
    rd(3'd1, "R8 unarmed write", v); chk("R8 ovf kept", v & 8'h01, 8'h01);
    wr(3'd1, 8'hFF); rd(3'd1, "R8 write one", v);
    wr(3'd1, 8'h00);
    rd(3'd1, "R8 armed clear", v); chk("R8 ovf cleared", v & 8'h07, 8'h00);

    // R10 counter load and hold of read data
    wr(3'd4, 8'h5A); rd(3'd4, "R10 load", v); chk("R10 load const", v, 8'h5A);
    idle(3); chk("R10 rdata held", bus_rdata, 8'h5A);

    // random mix on both banks (R2..R10 via model)
    pend = 0;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (pend) chk("R10 random read", bus_rdata, m_rd);
      bus_wr = 0; bus_rd = 0; pend = 0;
      tick_en = 3'($urandom);
      a = 3'($urandom_range(0, 5)); if (a == 3'd5) a = 3'd7;
      case ($urandom_range(0, 7))
        0: begin bus_wr = 1; bus_addr = a; bus_wdata = 8'($urandom);
                 if (a != 3'd7 && a != 3'd0 && $urandom_range(0, 1) == 1) bus_wdata = 8'($urandom_range(0, 6)); end
        1, 2: begin bus_rd = 1; bus_addr = a; pend = 1; end
        default: ;
      endcase
    end
    @(negedge clk);
    if (pend) chk("R10 random read", bus_rdata, m_rd);
    bus_wr = 0; bus_rd = 0;
    idle(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule